// File: doc/BRIEF.md
# Multi-depth pixel unpacker with palette

The block sits between a line FIFO of 32-bit words and the colour outputs of a display pipeline. On every clock in which the blanking input is low it produces one 24-bit RGB pixel, taking the pixel from the word at the head of a show-ahead FIFO. It pops the FIFO as soon as the last bit of a word has been used. The pixel format is chosen by two static inputs: a 2-bit depth code and a pseudo-colour select that only matters at 8 bits per pixel.

Five formats are handled. There is 8-bit grayscale, and 8-bit indexed colour through a 256-entry lookup table held inside the block. There is also 16-bit 5-6-5 colour, 24-bit colour packed four pixels to three words across word boundaries, and 32-bit words of which only the low 24 bits are shown. All formats take the same two cycles from a visible input cycle to the registered output, so the external timing logic sees one fixed delay. A `pix_valid` output marks the output cycles that carry a pixel. Software or a loader fills the lookup table through a simple write port.

Top module: `pix_unpack`

## Requirements
- R1: While reset is asserted and on the first cycle after its release, `pix_valid` is 0 and `pix_rgb` is 0. With `blank` high, `fifo_pop` stays 0.
- R2: A cycle with `blank` low produces exactly one pixel. That pixel appears on `pix_rgb` with `pix_valid` high two clock cycles later. A cycle with `blank` high produces no pixel and never asserts `fifo_pop`.
- R3: With depth code 0 (8 bits per pixel) and `pseudo` low, the pixels are the bytes of the head word from bit 31 down to bit 0. Each byte is copied to all three channels, and the word is popped with its fourth pixel.
- R4: With depth code 0 and `pseudo` high, each byte, in the same order, indexes the lookup table. The output is bits 23:0 of that entry, with the same two-cycle latency as the other formats.
- R5: A cycle with `pal_we` high writes `pal_wdata` into the entry at `pal_waddr`. Bits 31:24 of an entry never reach the output.
- R6: With depth code 1 (16 bits per pixel), bits 31:16 of a word come first, then bits 15:0. A halfword h becomes {h[15:11],000, h[10:5],00, h[4:0],000}, and the word is popped with its second pixel.
- R7: With depth code 2 (packed 24 bits), each group of three words A, B, C gives four pixels: A[31:8], {A[7:0],B[31:16]}, {B[15:0],C[31:24]}, and C[23:0]. A is popped with pixel 0, B with pixel 1 and C with pixel 3.
- R8: With depth code 3 (32 bits per pixel), each visible cycle shows bits 23:0 of the head word and pops it.
- R9: When the depth code or `pseudo` changes, the next visible pixel starts at the top of the current head word. A word that was partly used and not yet popped is read again from its first pixel.
- R10: Blanking cycles placed between the pixels of one word do not change the position within the word or within a 24-bit group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| depth | input | 2 | Depth code: 0 = 8, 1 = 16, 2 = packed 24, 3 = 32 bits per pixel |
| pseudo | input | 1 | At depth code 0: 1 = lookup-table index, 0 = grayscale |
| blank | input | 1 | High outside the visible region |
| fifo_data | input | 32 | Word at the head of the show-ahead FIFO |
| fifo_pop | output | 1 | Removes the head word at this clock edge |
| pal_we | input | 1 | Lookup-table write enable |
| pal_waddr | input | 8 | Lookup-table write index |
| pal_wdata | input | 32 | Lookup-table write data, low 24 bits are RGB |
| pix_valid | output | 1 | `pix_rgb` carries a pixel this cycle |
| pix_rgb | output | 24 | Pixel as {red, green, blue} |

## Verification
The bench builds the block with its default parameters: an 8-bit palette index, which gives 256 entries, and 32-bit words. Every byte value of the FIFO data therefore reaches its own palette entry. Each entry is filled with a pattern whose top byte differs from the rest, so any upper bits that leak through the indexed path show up as a mismatch. The same settings let long streams pass through every phase of the 24-bit group, with blanking gaps and format changes placed in the middle of a word.

// File: rtl/pix_unpack_pkg.sv
package pix_unpack_pkg;

    localparam int WORD_W    = 32;
    localparam int RGB_W     = 24;
    localparam int CH_W      = RGB_W / 3;
    localparam int PAL_IDX_W = 8;
    localparam int PAL_DEPTH = 1 << PAL_IDX_W;
    localparam int HOLD_W    = WORD_W / 2;
    localparam int LANES     = WORD_W / CH_W;

    typedef enum logic [1:0] {
        DEPTH_8  = 2'd0,
        DEPTH_16 = 2'd1,
        DEPTH_24 = 2'd2,
        DEPTH_32 = 2'd3
    } depth_e;

    typedef struct packed {
        logic [1:0]        phase;
        logic [HOLD_W-1:0] hold;
        logic [2:0]        cfg;
        logic              s1_valid;
        logic              s1_pal;
        logic [RGB_W-1:0]  s1_rgb;
        logic              out_valid;
        logic [RGB_W-1:0]  out_rgb;
    } unpack_state_t;

endpackage

// File: rtl/pix_fmt_decode.sv
module pix_fmt_decode
    import pix_unpack_pkg::*;
(
    input  depth_e                depth,
    input  logic [1:0]            phase,
    input  logic [WORD_W-1:0]     head,
    input  logic [HOLD_W-1:0]     hold,
    output logic [RGB_W-1:0]      rgb,
    output logic [PAL_IDX_W-1:0]  idx,
    output logic                  pop,
    output logic                  last
);

    logic [CH_W-1:0] lane [LANES];
    logic [CH_W-1:0] sel_byte;
    logic [15:0]     half;

    // byte lanes, most significant first
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lane[k] = head[WORD_W-1-k*CH_W -: CH_W];
    end

    always_comb begin
        sel_byte = lane[phase];
        half     = phase[0] ? head[15:0] : head[31:16];
        idx      = sel_byte;
        rgb      = '0;
        pop      = 1'b0;
        last     = 1'b0;
        unique case (depth)
            DEPTH_8: begin
                rgb  = {sel_byte, sel_byte, sel_byte};
                last = (phase == 2'd3);
                pop  = last;
            end
            DEPTH_16: begin
                rgb  = {half[15:11], 3'b000, half[10:5], 2'b00, half[4:0], 3'b000};
                last = phase[0];
                pop  = last;
            end
            DEPTH_24: begin
                unique case (phase)
                    2'd0: rgb = head[31:8];
                    2'd1: rgb = {hold[7:0], head[31:16]};
                    2'd2: rgb = {hold[15:0], head[31:24]};
                    default: rgb = head[23:0];
                endcase
                last = (phase == 2'd3);
                pop  = (phase != 2'd2);
            end
            default: begin
                rgb  = head[RGB_W-1:0];
                last = 1'b1;
                pop  = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/pix_palette.sv
module pix_palette #(
    parameter int IDX_W  = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [IDX_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (re) begin
            rdata_q <= mem_q[raddr];
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/pix_unpack.sv
module pix_unpack
    import pix_unpack_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           depth,
    input  logic                 pseudo,
    input  logic                 blank,
    input  logic [WORD_W-1:0]    fifo_data,
    output logic                 fifo_pop,
    input  logic                 pal_we,
    input  logic [PAL_IDX_W-1:0] pal_waddr,
    input  logic [WORD_W-1:0]    pal_wdata,
    output logic                 pix_valid,
    output logic [RGB_W-1:0]     pix_rgb
);

    unpack_state_t st_d, st_q;

    depth_e                depth_e_w;
    logic [2:0]            cfg_now;
    logic                  cfg_chg;
    logic [1:0]            phase_eff;
    logic                  visible;
    logic                  use_pal;
    logic [RGB_W-1:0]      dec_rgb;
    logic [PAL_IDX_W-1:0]  dec_idx;
    logic                  dec_pop;
    logic                  dec_last;
    logic [WORD_W-1:0]     pal_rd;
    logic [WORD_W-RGB_W-1:0] pal_hi_unused;

    assign depth_e_w = depth_e'(depth);
    assign cfg_now   = {depth, pseudo};
    assign cfg_chg   = (cfg_now != st_q.cfg);
    assign phase_eff = cfg_chg ? 2'd0 : st_q.phase;
    assign visible   = !blank;
    assign use_pal   = (depth_e_w == DEPTH_8) && pseudo;

    pix_fmt_decode u_decode (
        .depth (depth_e_w),
        .phase (phase_eff),
        .head  (fifo_data),
        .hold  (st_q.hold),
        .rgb   (dec_rgb),
        .idx   (dec_idx),
        .pop   (dec_pop),
        .last  (dec_last)
    );

    pix_palette #(
        .IDX_W  (PAL_IDX_W),
        .DATA_W (WORD_W)
    ) u_palette (
        .clk   (clk),
        .we    (pal_we),
        .waddr (pal_waddr),
        .wdata (pal_wdata),
        .re    (visible && use_pal),
        .raddr (dec_idx),
        .rdata (pal_rd)
    );

    assign pal_hi_unused = pal_rd[WORD_W-1:RGB_W];

    always_comb begin
        st_d     = st_q;
        st_d.cfg = cfg_now;

        // position within word / 24-bit group
        if (visible) begin
            st_d.phase = dec_last ? 2'd0 : phase_eff + 2'd1;
            if (dec_pop) begin
                st_d.hold = fifo_data[HOLD_W-1:0];
            end
        end else begin
            st_d.phase = phase_eff;
        end

        // stage 1: decoded pixel, palette read in flight
        st_d.s1_valid = visible;
        st_d.s1_pal   = use_pal;
        st_d.s1_rgb   = dec_rgb;

        // stage 2: registered output
        st_d.out_valid = st_q.s1_valid;
        if (st_q.s1_valid) begin
            st_d.out_rgb = st_q.s1_pal ? pal_rd[RGB_W-1:0] : st_q.s1_rgb;
        end else begin
            st_d.out_rgb = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: 2'd0, hold: '0, cfg: 3'd0, s1_valid: 1'b0,
                      s1_pal: 1'b0, s1_rgb: '0, out_valid: 1'b0, out_rgb: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign fifo_pop  = visible && dec_pop;
    assign pix_valid = st_q.out_valid;
    assign pix_rgb   = st_q.out_rgb;

endmodule

// File: rtl/pix_unpack_chk.sv
module pix_unpack_chk
    import pix_unpack_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       depth,
    input logic             pseudo,
    input logic             blank,
    input logic             fifo_pop,
    input logic             pix_valid,
    input logic [RGB_W-1:0] pix_rgb
);

    logic       vis_p1, vis_p2;
    logic [1:0] dep_p1, dep_p2;
    logic       ps_p1, ps_p2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vis_p1 <= 1'b0;
            vis_p2 <= 1'b0;
            dep_p1 <= 2'd0;
            dep_p2 <= 2'd0;
            ps_p1  <= 1'b0;
            ps_p2  <= 1'b0;
        end else begin
            vis_p1 <= !blank;
            vis_p2 <= vis_p1;
            dep_p1 <= depth;
            dep_p2 <= dep_p1;
            ps_p1  <= pseudo;
            ps_p2  <= ps_p1;
        end
    end

    // R2
    no_pop_in_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blank |-> !fifo_pop);

    // R2
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid == vis_p2);

    // R8
    pop_every_word32_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!blank && depth == 2'd3) |-> fifo_pop);

    // R3
    pop_spacing8_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_pop && depth == 2'd0) |=> !(fifo_pop && depth == 2'd0));

    // R3
    gray_replicate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && dep_p2 == 2'd0 && !ps_p2) |->
        (pix_rgb[23:16] == pix_rgb[15:8] && pix_rgb[15:8] == pix_rgb[7:0]));

    // R6
    rgb565_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && dep_p2 == 2'd1) |->
        (pix_rgb[18:16] == 3'd0 && pix_rgb[9:8] == 2'd0 && pix_rgb[2:0] == 3'd0));

endmodule

bind pix_unpack pix_unpack_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .depth     (depth),
    .pseudo    (pseudo),
    .blank     (blank),
    .fifo_pop  (fifo_pop),
    .pix_valid (pix_valid),
    .pix_rgb   (pix_rgb)
);

// File: tb/pix_unpack_tb_top.sv
module pix_unpack_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b1;
    logic [1:0]  depth = 2'd0;
    logic        pseudo = 1'b0;
    logic        blank = 1'b1;
    logic [31:0] fifo_data;
    logic        fifo_pop;
    logic        pal_we = 1'b0;
    logic [7:0]  pal_waddr = 8'd0;
    logic [31:0] pal_wdata = 32'd0;
    logic        pix_valid;
    logic [23:0] pix_rgb;

    logic [31:0] fmem [0:1023];
    logic [31:0] palm [0:255];
    logic [23:0] cap  [0:63];
    int          ptr = 0;
    int          n_chk = 0;
    int          n_err = 0;
    int          wd = 0;

    typedef struct packed {
        logic [1:0] d;
        logic       ps;
        logic [3:0] gap;
        logic [7:0] n;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{d: 2'd0, ps: 1'b0, gap: 4'd0, n: 8'd24},
        '{d: 2'd0, ps: 1'b1, gap: 4'd0, n: 8'd32},
        '{d: 2'd1, ps: 1'b0, gap: 4'd3, n: 8'd16},
        '{d: 2'd2, ps: 1'b0, gap: 4'd0, n: 8'd24},
        '{d: 2'd2, ps: 1'b0, gap: 4'd4, n: 8'd24},
        '{d: 2'd3, ps: 1'b0, gap: 4'd0, n: 8'd12},
        '{d: 2'd0, ps: 1'b0, gap: 4'd5, n: 8'd16},
        '{d: 2'd0, ps: 1'b1, gap: 4'd3, n: 8'd16}
    };

    always #4 clk = ~clk;

    assign fifo_data = fmem[ptr];

    always @(posedge clk) begin
        if (fifo_pop) ptr <= ptr + 1;
    end

    pix_unpack dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .depth     (depth),
        .pseudo    (pseudo),
        .blank     (blank),
        .fifo_data (fifo_data),
        .fifo_pop  (fifo_pop),
        .pal_we    (pal_we),
        .pal_waddr (pal_waddr),
        .pal_wdata (pal_wdata),
        .pix_valid (pix_valid),
        .pix_rgb   (pix_rgb)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [23:0] w565(input logic [15:0] h);
        return {h[15:11], 3'b000, h[10:5], 2'b00, h[4:0], 3'b000};
    endfunction

    function automatic logic [23:0] exp_pix(input int d, input bit ps, input int base, input int n);
        logic [31:0] a, b, c;
        logic [7:0]  by;
        case (d)
            0: begin
                a  = fmem[base + n / 4];
                by = 8'((a >> (24 - 8 * (n % 4))) & 32'hff);
                return ps ? palm[by][23:0] : {by, by, by};
            end
            1: begin
                a = fmem[base + n / 2];
                return w565((n % 2 == 0) ? a[31:16] : a[15:0]);
            end
            2: begin
                a = fmem[base + 3 * (n / 4)];
                b = fmem[base + 3 * (n / 4) + 1];
                c = fmem[base + 3 * (n / 4) + 2];
                case (n % 4)
                    0: return a[31:8];
                    1: return {a[7:0], b[31:16]};
                    2: return {b[15:0], c[31:24]};
                    default: return c[23:0];
                endcase
            end
            default: return fmem[base + n][23:0];
        endcase
    endfunction

    function automatic string req_of(input int d, input bit ps, input int gap);
        if (gap > 1) return "R10";
        case (d)
            0: return ps ? "R4" : "R3";
            1: return "R6";
            2: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic pal_write(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        pal_we = 1'b1;
        pal_waddr = a;
        pal_wdata = v;
        palm[a] = v;
        @(negedge clk);
        pal_we = 1'b0;
    endtask

    task automatic set_cfg(input logic [1:0] d, input logic ps);
        @(negedge clk);
        blank = 1'b1;
        depth = d;
        pseudo = ps;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic stream(input int n, input int gap);
        int got = 0;
        int issued = 0;
        int cyc = 0;
        while (got < n) begin
            @(negedge clk);
            if (pix_valid) begin
                if (got < 64) cap[got] = pix_rgb;
                got++;
            end
            if (issued < n && !(gap > 1 && (cyc % gap) == gap - 1)) begin
                blank = 1'b0;
                issued++;
            end else begin
                blank = 1'b1;
            end
            cyc++;
        end
        blank = 1'b1;
    endtask

    task automatic run_case(input vec_t v);
        int base;
        int words;
        string rq;
        rq = req_of(v.d, v.ps, v.gap);
        set_cfg(v.d, v.ps);
        base = ptr;
        stream(v.n, v.gap);
        for (int i = 0; i < v.n; i++) begin
            check(rq, {8'd0, cap[i]}, {8'd0, exp_pix(v.d, v.ps, base, i)});
        end
        @(negedge clk);
        check("R2", {31'd0, pix_valid}, 32'd0);
        @(negedge clk);
        case (v.d)
            2'd0: words = v.n / 4;
            2'd1: words = v.n / 2;
            2'd2: words = 3 * v.n / 4;
            default: words = v.n;
        endcase
        check(rq, ptr - base, words);
    endtask

    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 100000) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog actual=%0d expected<=100000", wd);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int base;
        for (int k = 0; k < 1024; k++) begin
            fmem[k] = (32'h9E37_79B9 * (k + 1)) ^ (k << 7);
        end
        #1 rst_n = 1'b0;
        @(negedge clk);
        // R1: quiet during reset
        check("R1", {31'd0, pix_valid}, 32'd0);
        check("R1", {8'd0, pix_rgb}, 32'd0);
        check("R1", {31'd0, fifo_pop}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {31'd0, pix_valid}, 32'd0);
        check("R1", {8'd0, pix_rgb}, 32'd0);

        // R5: palette fill, upper byte distinct
        for (int i = 0; i < 256; i++) begin
            pal_write(8'(i), {~8'(i), 8'(i * 37), 8'(i) ^ 8'hC3, 8'(i + 11)});
        end

        for (int t = 0; t < 8; t++) begin
            run_case(VECS[t]);
        end

        // R9: change mid-group, restart at head word
        set_cfg(2'd2, 1'b0);
        base = ptr;
        stream(2, 0);
        check("R9", {8'd0, cap[0]}, {8'd0, fmem[base][31:8]});
        check("R9", {8'd0, cap[1]}, {8'd0, fmem[base][7:0], fmem[base + 1][31:16]});
        set_cfg(2'd3, 1'b0);
        stream(1, 0);
        check("R9", {8'd0, cap[0]}, {8'd0, fmem[base + 2][23:0]});
        @(negedge clk);
        check("R9", ptr, base + 3);
        set_cfg(2'd0, 1'b0);
        stream(2, 0);
        check("R9", {8'd0, cap[1]}, {8'd0, {3{fmem[base + 3][23:16]}}});
        set_cfg(2'd1, 1'b0);
        stream(1, 0);
        check("R9", {8'd0, cap[0]}, {8'd0, w565(fmem[base + 3][31:16])});
        set_cfg(2'd0, 1'b0);
        stream(1, 0);
        check("R9", {8'd0, cap[0]}, {8'd0, {3{fmem[base + 3][31:24]}}});
        // pseudo toggle alone also restarts
        @(negedge clk);
        pseudo = 1'b1;
        stream(1, 0);
        check("R9", {8'd0, cap[0]}, {8'd0, palm[fmem[base + 3][31:24]][23:0]});
        @(negedge clk);
        check("R9", ptr, base + 3);

        // R5: rewrite one entry, upper byte masked
        set_cfg(2'd3, 1'b0);
        fmem[ptr] = 32'h0707_0707;
        pal_write(8'h07, 32'hFF12_3456);
        set_cfg(2'd0, 1'b1);
        base = ptr;
        stream(4, 0);
        for (int i = 0; i < 4; i++) begin
            check("R5", {8'd0, cap[i]}, 32'h0012_3456);
        end
        @(negedge clk);
        check("R5", ptr, base + 1);

        // R2: long blanking, no pops and no pixels
        blank = 1'b1;
        base = ptr;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check("R2", {31'd0, pix_valid}, 32'd0);
        end
        check("R2", ptr, base);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule